// File: doc/BRIEF.md
# Bus-to-Stream Command Bridge

The bridge connects a simple single-word memory-mapped processor port to a coprocessor. The coprocessor has two streaming channels that work on their own: a command stream that the bridge writes into, and a result stream that the bridge reads from. The processor side follows a minimal core protocol. The master presents one command for a single cycle and then waits for one data-valid response. It issues nothing else while that command is outstanding.

Values on the stream side are twice the bus width. Software writes a wide value as two word writes to the data port. The first write is held in a staging register, and the second write pushes both halves together as one stream word. A wide result is popped in one step. Its low half is returned at once and its high half is kept for the next data read. This way a wide quantity, such as a time stamp, never tears between its halves. A second port returns a status word, so software can poll before it commits to a transfer that may stall.

Back-pressure rules on the streams: a word moves on a clock edge where valid and ready are both high. Once the bridge raises `cmd_valid`, it holds it and keeps `cmd_data` stable until `cmd_ready` is seen. The bridge raises `res_ready` only while `res_valid` is high, and it pops exactly one word for that edge.

Top module: `ocp_stream_bridge`

## Requirements
- R1: Only `bus_addr` equal to BASE_ADDR (data port) or BASE_ADDR+4 (status port) is decoded. A command to any other address, misaligned ones included, gets no response, moves no stream word and leaves both half pointers unchanged.
- R2: A read of the status port returns bit 0 = `res_valid`, bit 1 = not `cmd_ready`, bit 2 = a low command half is staged, bit 3 = a high result half is staged, and all other bits zero. A write to the status port is acknowledged and has no effect.
- R3: The first data-port write of a pair only stages its word and is acknowledged without a push. The second write pushes one stream word, with the second word in bits [2W-1:W] and the staged word in bits [W-1:0].
- R4: The first data-port read of a pair pops one stream word and returns bits [W-1:0]. The second read returns bits [2W-1:W] of that same word without a pop.
- R5: A second-half write while `cmd_ready` is low keeps `cmd_valid` high with stable data and sends no response. The response appears in the cycle after the word is transferred.
- R6: A low-half read while `res_valid` is low sends no response and keeps `res_ready` low until a word arrives. The word is popped on the first edge where it is valid, and the response follows in the next cycle.
- R7: Command encoding is 0 = idle, 1 = write, 2 = read. Response encoding is 0 = none, 1 = data valid. Each decoded command gets exactly one data-valid response. When nothing stalls, the response comes in the cycle after the command.
- R8: Reset clears both staging registers and returns both half pointers to the low half. During reset the bridge sends no response and does not assert `cmd_valid` or `res_ready`.
- R9: The write half pointer and the read half pointer are independent. A data read between the two halves of a write, or a write between the two halves of a read, does not disturb the other pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cmd | input | 3 | Bus command: 0 idle, 1 write, 2 read |
| bus_addr | input | ADDR_W | Byte address of the command |
| bus_wdata | input | BUS_W | Write data |
| bus_resp | output | 2 | Response: 0 none, 1 data valid |
| bus_rdata | output | BUS_W | Read data, valid with the response |
| cmd_valid | output | 1 | Command stream word valid |
| cmd_ready | input | 1 | Command stream can accept (low = full) |
| cmd_data | output | 2*BUS_W | Command stream word |
| res_valid | input | 1 | Result stream has a word |
| res_ready | output | 1 | Pop the result stream word |
| res_data | input | 2*BUS_W | Result stream word |

## Verification
The bench builds the bridge with its defaults: a 32-bit bus, a 32-bit address and the base at 0xF0000A00, so stream words are 64 bits wide. These values let exact address compares reach both mapped ports and the unmapped neighbours (the next word, a misaligned byte, a different page). Distinct 32-bit patterns in each half show any swap or tearing of halves. A behavioural response budget, checked on every clock, catches a response that appears without a command or appears twice. Delayed release of the stream handshakes then shows the exact stall-to-response latency.

// File: rtl/ocp_bridge_pkg.sv
package ocp_bridge_pkg;
  typedef enum logic [2:0] {
    BUS_IDLE = 3'b000,
    BUS_WR   = 3'b001,
    BUS_RD   = 3'b010
  } bus_cmd_e;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_DVA  = 2'b01
  } bus_resp_e;

  // kind of work a decoded command asks for
  typedef enum logic [1:0] {
    K_WDATA = 2'b00,
    K_RDATA = 2'b01,
    K_RSTAT = 2'b10,
    K_WSTAT = 2'b11
  } req_kind_e;

  localparam int STAT_RES_AVAIL = 0;
  localparam int STAT_CMD_FULL  = 1;
  localparam int STAT_WR_HALF   = 2;
  localparam int STAT_RD_HALF   = 3;
endpackage

// File: rtl/bridge_addr_decode.sv
module bridge_addr_decode
  import ocp_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hF000_0A00
) (
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output req_kind_e         kind
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(4);

  logic is_wr, is_rd, at_data, at_stat;

  always_comb begin
    is_wr   = (cmd == BUS_WR);
    is_rd   = (cmd == BUS_RD);
    at_data = (addr == BASE_ADDR);
    at_stat = (addr == STAT_ADDR);
    hit     = (is_wr || is_rd) && (at_data || at_stat);
    if (at_data) kind = is_wr ? K_WDATA : K_RDATA;
    else         kind = is_wr ? K_WSTAT : K_RSTAT;
  end
endmodule

// File: rtl/bridge_wr_gather.sv
module bridge_wr_gather #(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act,
  input  logic [BUS_W-1:0]   wdata,
  input  logic               st_ready,
  output logic               done,
  output logic               st_valid,
  output logic [2*BUS_W-1:0] st_data,
  output logic               lo_held
);
  logic [BUS_W-1:0] lo_q;
  logic             half_q;

  always_comb begin
    st_valid = act && half_q;
    st_data  = {wdata, lo_q};
    done     = act && (!half_q || st_ready);
    lo_held  = half_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      half_q <= 1'b0;
    end else if (done) begin
      if (!half_q) lo_q <= wdata;
      half_q <= !half_q;
    end
  end
endmodule

// File: rtl/bridge_rd_split.sv
module bridge_rd_split #(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act,
  input  logic               src_valid,
  input  logic [2*BUS_W-1:0] src_data,
  output logic               done,
  output logic               src_ready,
  output logic [BUS_W-1:0]   word,
  output logic               hi_held
);
  logic [BUS_W-1:0] hi_q;
  logic             half_q;

  always_comb begin
    src_ready = act && !half_q && src_valid;
    done      = act && (half_q || src_valid);
    word      = half_q ? hi_q : src_data[BUS_W-1:0];
    hi_held   = half_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      half_q <= 1'b0;
    end else if (done) begin
      if (!half_q) hi_q <= src_data[2*BUS_W-1:BUS_W];
      half_q <= !half_q;
    end
  end
endmodule

// File: rtl/ocp_stream_bridge.sv
module ocp_stream_bridge
  import ocp_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hF000_0A00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         bus_cmd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [1:0]         bus_resp,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [2*BUS_W-1:0] cmd_data,
  input  logic               res_valid,
  output logic               res_ready,
  input  logic [2*BUS_W-1:0] res_data
);
  localparam int WIDE_W = 2 * BUS_W;

  logic             live_hit;
  req_kind_e        live_kind;
  logic             pend_q;
  req_kind_e        pend_kind_q;
  logic [BUS_W-1:0] pend_wdata_q;

  logic             act_valid;
  req_kind_e        act_kind;
  logic [BUS_W-1:0] act_wdata;
  logic             wr_done, wr_lo_held;
  logic             rd_done, rd_hi_held;
  logic [BUS_W-1:0] rd_word, stat_word, rsp_word;
  logic             complete;
  bus_resp_e        resp_q;
  logic [BUS_W-1:0] rdata_q;

  bridge_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .cmd  (bus_cmd),
    .addr (bus_addr),
    .hit  (live_hit),
    .kind (live_kind)
  );

  // a held command has priority; a new one is taken only when idle
  always_comb begin
    act_valid = pend_q || live_hit;
    act_kind  = pend_q ? pend_kind_q  : live_kind;
    act_wdata = pend_q ? pend_wdata_q : bus_wdata;
  end

  bridge_wr_gather #(.BUS_W(BUS_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act_valid && act_kind == K_WDATA),
    .wdata    (act_wdata),
    .st_ready (cmd_ready),
    .done     (wr_done),
    .st_valid (cmd_valid),
    .st_data  (cmd_data),
    .lo_held  (wr_lo_held)
  );

  bridge_rd_split #(.BUS_W(BUS_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act_valid && act_kind == K_RDATA),
    .src_valid (res_valid),
    .src_data  (res_data),
    .done      (rd_done),
    .src_ready (res_ready),
    .word      (rd_word),
    .hi_held   (rd_hi_held)
  );

  always_comb begin
    stat_word                 = '0;
    stat_word[STAT_RES_AVAIL] = res_valid;
    stat_word[STAT_CMD_FULL]  = !cmd_ready;
    stat_word[STAT_WR_HALF]   = wr_lo_held;
    stat_word[STAT_RD_HALF]   = rd_hi_held;
  end

  always_comb begin
    case (act_kind)
      K_WDATA: complete = act_valid && wr_done;
      K_RDATA: complete = act_valid && rd_done;
      default: complete = act_valid;
    endcase
    case (act_kind)
      K_RDATA: rsp_word = rd_word;
      K_RSTAT: rsp_word = stat_word;
      default: rsp_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      pend_kind_q  <= K_WDATA;
      pend_wdata_q <= '0;
      resp_q       <= RSP_NONE;
      rdata_q      <= '0;
    end else begin
      resp_q  <= complete ? RSP_DVA : RSP_NONE;
      rdata_q <= complete ? rsp_word : '0;
      if (act_valid && !complete) begin
        pend_q       <= 1'b1;
        pend_kind_q  <= act_kind;
        pend_wdata_q <= act_wdata;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  assign bus_resp  = resp_q;
  assign bus_rdata = rdata_q;

  logic unused_w;
  assign unused_w = (WIDE_W == 0);
endmodule

// File: rtl/ocp_stream_bridge_chk.sv
module ocp_stream_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hF000_0A00
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         bus_cmd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [1:0]         bus_resp,
  input logic [BUS_W-1:0]   bus_rdata,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [2*BUS_W-1:0] cmd_data,
  input logic               res_valid,
  input logic               res_ready,
  input logic [2*BUS_W-1:0] res_data,
  input logic               busy
);
  logic stray;
  assign stray = !busy && (bus_cmd == 3'b001 || bus_cmd == 3'b010) &&
                 bus_addr != BASE_ADDR && bus_addr != BASE_ADDR + ADDR_W'(4);

  AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    stray |=> bus_resp == 2'b00); // R1
  AST_STATUS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_cmd == 3'b010 && bus_addr == BASE_ADDR + ADDR_W'(4)) |=> bus_resp == 2'b01); // R2
  AST_PUSH_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> bus_resp == 2'b01); // R5
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_data)); // R5
  AST_POP_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> res_valid); // R6
  AST_POP_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> bus_resp == 2'b01 && bus_rdata == $past(res_data[BUS_W-1:0])); // R4
  AST_RESP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_resp[1] == 1'b0); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> bus_resp == 2'b00); // R8
endmodule

bind ocp_stream_bridge ocp_stream_bridge_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_resp(bus_resp), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_data(cmd_data), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .busy(pend_q)
);

// File: tb/ocp_stream_bridge_test.sv
module ocp_stream_bridge_test;
  localparam logic [31:0] DPORT = 32'hF000_0A00;
  localparam logic [31:0] SPORT = 32'hF000_0A04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_cmd = 3'd0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_resp;
  logic [31:0] bus_rdata;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [63:0] cmd_data;
  logic        res_valid;
  logic        res_ready;
  logic [63:0] res_data;

  always #2 clk = ~clk;

  ocp_stream_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_resp(bus_resp), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  // coprocessor stream models
  logic [63:0] src_arr [16];
  logic [63:0] got_arr [16];
  int src_n = 0, rd_idx = 0, got_n = 0;
  assign res_valid = (rd_idx < src_n);
  assign res_data  = src_arr[rd_idx % 16];

  always @(posedge clk) begin
    if (res_valid && res_ready) rd_idx <= rd_idx + 1;
    if (cmd_valid && cmd_ready) begin
      got_arr[got_n % 16] <= cmd_data;
      got_n <= got_n + 1;
    end
  end

  int vectors = 0, miscompares = 0, budget = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every clock: a response must be owed by an issued command (R7)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done_flag) begin
      if (bus_resp == 2'b01) begin
        check(budget > 0, "R7 response without command", 64'(bus_resp), 64'd0);
        if (budget > 0) budget--;
      end else begin
        check(bus_resp == 2'b00, "R7 response code", 64'(bus_resp), 64'd0);
      end
    end
  end

  task automatic bus(input bit wr, input logic [31:0] a, input logic [31:0] d,
                     input bit mapped, output logic [31:0] rd, output int lat);
    @(negedge clk);
    bus_cmd = wr ? 3'd1 : 3'd2; bus_addr = a; bus_wdata = d;
    if (mapped) budget++;
    @(negedge clk);
    bus_cmd = 3'd0; lat = 1;
    while (bus_resp != 2'b01 && lat < 8) begin
      @(negedge clk); lat++;
    end
    rd = bus_rdata;
  endtask

  task automatic push_src(input logic [63:0] w);
    src_arr[src_n % 16] = w; src_n++;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [31:0] r; int lat; int g0; int i0;
    repeat (3) @(negedge clk);
    check(bus_resp == 0 && !cmd_valid && !res_ready, "R8 reset outputs",
          {bus_resp, cmd_valid, res_ready}, 0);
    rst_n = 1;

    // status basics
    bus(0, SPORT, 0, 1, r, lat);
    check(r == 0 && lat == 1, "R2 status idle", {r, lat}, {32'd0, 32'd1});
    cmd_ready = 0;
    bus(0, SPORT, 0, 1, r, lat);
    check(r == 32'h2, "R2 status cmd full", r, 2);
    cmd_ready = 1;
    g0 = got_n;
    bus(1, SPORT, 32'hFFFF_FFFF, 1, r, lat);
    check(lat == 1 && got_n == g0, "R2 status write ignored", got_n, g0);
    bus(0, SPORT, 0, 1, r, lat);
    check(r == 0, "R2 status after status write", r, 0);

    // gathered write
    bus(1, DPORT, 32'h1111_1111, 1, r, lat);
    check(lat == 1 && got_n == g0, "R3 low half staged only", got_n, g0);
    bus(0, SPORT, 0, 1, r, lat);
    check(r == 32'h4, "R2 low half staged bit", r, 4);
    bus(1, DPORT, 32'h2222_2222, 1, r, lat);
    check(lat == 1, "R7 write latency", lat, 1);
    check(got_n == g0 + 1 && got_arr[g0 % 16] == 64'h2222_2222_1111_1111, "R3 pushed word",
          got_arr[g0 % 16], 64'h2222_2222_1111_1111);

    // write back-pressure
    bus(1, DPORT, 32'hAAAA_0001, 1, r, lat);
    cmd_ready = 0;
    fork begin repeat (5) @(negedge clk); cmd_ready = 1; end join_none
    bus(1, DPORT, 32'hBBBB_0002, 1, r, lat);
    check(lat == 5, "R5 stalled write latency", lat, 5);
    check(got_n == g0 + 2 && got_arr[(g0 + 1) % 16] == 64'hBBBB_0002_AAAA_0001, "R5 stalled push",
          got_arr[(g0 + 1) % 16], 64'hBBBB_0002_AAAA_0001);

    // split read
    push_src(64'h0123_4567_89AB_CDEF);
    i0 = rd_idx;
    bus(0, DPORT, 0, 1, r, lat);
    check(r == 32'h89AB_CDEF && lat == 1, "R4 low half read", r, 32'h89AB_CDEF);
    bus(0, SPORT, 0, 1, r, lat);
    check(r == 32'h8, "R2 high half staged bit", r, 8);
    bus(0, DPORT, 0, 1, r, lat);
    check(r == 32'h0123_4567 && rd_idx == i0 + 1, "R4 high half read single pop", r, 32'h0123_4567);

    // read stall
    fork begin repeat (5) @(negedge clk); push_src(64'hFEDC_BA98_7654_3210); end join_none
    bus(0, DPORT, 0, 1, r, lat);
    check(r == 32'h7654_3210 && lat == 5, "R6 stalled read", {r, lat}, {32'h7654_3210, 32'd5});
    bus(0, DPORT, 0, 1, r, lat);
    check(r == 32'hFEDC_BA98, "R6 high after stall", r, 32'hFEDC_BA98);

    // unmapped addresses
    g0 = got_n; i0 = rd_idx;
    push_src(64'h5555_5555_5555_5555);
    bus(1, 32'hF000_0A08, 32'h5, 0, r, lat);
    check(lat == 8 && bus_resp == 0, "R1 no response next word", lat, 8);
    bus(0, 32'hF000_0B00, 0, 0, r, lat);
    check(lat == 8 && rd_idx == i0, "R1 no pop other page", rd_idx, i0);
    bus(1, 32'hF000_0A02, 32'h6, 0, r, lat);
    check(lat == 8 && got_n == g0, "R1 misaligned ignored", got_n, g0);
    bus(0, SPORT, 0, 1, r, lat);
    check(r == 32'h1, "R1 pointers untouched", r, 1);
    bus(0, DPORT, 0, 1, r, lat);
    bus(0, DPORT, 0, 1, r, lat);
    check(r == 32'h5555_5555, "R4 drain", r, 32'h5555_5555);

    // interleaved pairs
    bus(1, DPORT, 32'h3333_0000, 1, r, lat);
    push_src(64'h9999_0000_8888_0000);
    bus(0, DPORT, 0, 1, r, lat);
    check(r == 32'h8888_0000, "R9 read between write halves", r, 32'h8888_0000);
    bus(0, SPORT, 0, 1, r, lat);
    check(r == 32'hC, "R9 both halves staged", r, 32'hC);
    bus(1, DPORT, 32'h4444_0000, 1, r, lat);
    check(got_arr[g0 % 16] == 64'h4444_0000_3333_0000, "R9 write pair intact",
          got_arr[g0 % 16], 64'h4444_0000_3333_0000);
    bus(0, DPORT, 0, 1, r, lat);
    check(r == 32'h9999_0000, "R9 read pair intact", r, 32'h9999_0000);

    // reset clears staging
    bus(1, DPORT, 32'h5555_0000, 1, r, lat);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check(bus_resp == 0 && !cmd_valid && !res_ready, "R8 quiet in reset", bus_resp, 0);
    rst_n = 1;
    bus(0, SPORT, 0, 1, r, lat);
    check(r == 0, "R8 pointers cleared", r, 0);
    g0 = got_n;
    bus(1, DPORT, 32'h6666_0000, 1, r, lat);
    bus(1, DPORT, 32'h7777_0000, 1, r, lat);
    check(got_n == g0 + 1 && got_arr[g0 % 16] == 64'h7777_0000_6666_0000, "R8 fresh pair",
          got_arr[g0 % 16], 64'h7777_0000_6666_0000);

    repeat (3) @(negedge clk);
    check(budget == 0, "R7 every command answered", budget, 0);
    finish_run();
  end
endmodule